// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the digital side of a three-wire serial port in front of a converter that keeps eight internal registers. The host reaches every register in the same way. It first shifts in a command byte, which names the target register, says whether the next transfer reads or writes it, and carries a three-bit channel selector. The transfer that follows is as long as the target register. Once it ends, the port waits for another command byte.

A converter core delivers results over a one-cycle strobe with a parallel word. Before each new result is latched, the ready flag is forced high for a fixed blanking window. The flag then drops to show that fresh data is waiting, and it rises again once the host has read a complete result word. The flag's current value also appears as the top bit when the command register is read back, so the host can poll it over the serial port.

The serial clock, chip select and data input are brought into the system clock domain and sampled there. Data is taken in on rising serial clock edges and changed on the output at falling edges, most significant bit first. If the host loses count of its bits, it can recover the port by holding the data input high for a run of clocks.

Top module: `serial_reg_access`

## Requirements
- R1: A command byte with bit 7 equal to 0 is accepted. Bits 6:4 select the target (0 command, 1 mode, 2 filter high, 3 filter low, 4 result, 5 to 7 auxiliary bytes). Bit 3 selects read (1) or write (0). Bits 2:0 load the channel output `chan_sel`. A write that targets the command register needs no data phase.
- R2: A command byte with bit 7 equal to 1 is ignored. It leaves `chan_sel` unchanged, and the port still expects a command byte next.
- R3: A write to the mode, filter or auxiliary registers takes 8 bits MSB first. The byte appears on `mode_q` (mode) or `filt_q` (filter high in bits 15:8, filter low in bits 7:0), and a later read returns it.
- R4: A read shifts out the target register MSB first on `dout`. A read of the command register returns the ready flag in bit 7 and command bits 6:0 in bits 6:0.
- R5: While `cs_n` is high, serial clock edges are ignored, the bit position is held, and `dout_oe` is low. `dout_oe` is high only while a read is under way with `cs_n` low.
- R6: The result register is read-only. It is 24 bits (`res_data`) when mode bit 0 is 1, and 16 bits (`res_data[23:8]`) when mode bit 0 is 0. A write to it still consumes that many bits, and the data is discarded.
- R7: After a `res_valid` strobe, `rdy_n` is high for at least BLANK_CYC clock cycles. The new word is then latched and `rdy_n` goes low.
- R8: `rdy_n` goes high after the last bit of a complete result read.
- R9: After reset, `filt_q` is 16'h0140, `mode_q` is 0, `chan_sel` is 0, `rdy_n` is 1 and `dout_oe` is 0.
- R10: When RESYNC_ONES consecutive sampled data bits are 1, the port drops any partial transfer and expects a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout` (tri-state control) |
| res_valid | input | 1 | One-cycle strobe for a new result |
| res_data | input | DATA_W | Result word |
| rdy_n | output | 1 | Ready flag, low when an unread result is held |
| chan_sel | output | 3 | Channel selector from the last accepted command |
| mode_q | output | 8 | Mode register |
| filt_q | output | 16 | Filter registers {high, low} |

## Verification
On every cycle the assertions check four things. They check the reset values. They check that the output enable stays low while chip select is high. They check that the ready flag rises right after a result strobe, and that it never falls before the blanking window has passed since the last strobe.

Other behaviours depend on a sequence of serial events, and only the bench scenarios can show them. These are the command decoding, readback order, discarded writes of 16 or 24 bits, ignored command bytes, bit position held across a chip-select gap, and recovery of the bit alignment after a run of ones.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic [2:0] {
    RG_COMM = 3'd0,
    RG_MODE = 3'd1,
    RG_FHI  = 3'd2,
    RG_FLO  = 3'd3,
    RG_RES  = 3'd4,
    RG_AUX0 = 3'd5,
    RG_AUX1 = 3'd6,
    RG_AUX2 = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } xfer_st_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_REGS = 8;
  localparam logic [7:0] FILT_HI_INIT = 8'h01;
  localparam logic [7:0] FILT_LO_INIT = 8'h40;
endpackage

// File: rtl/sra_serial_sync.sv
module sra_serial_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic din_s
);
  logic [SYNC_STAGES-1:0] sclk_p, cs_p, din_p;
  logic                   sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '1;
      cs_p   <= '1;
      din_p  <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      din_p  <= {din_p[SYNC_STAGES-2:0], din};
      sclk_d <= sclk_p[SYNC_STAGES-1];
    end
  end

  assign cs_act    = ~cs_p[SYNC_STAGES-1];
  assign din_s     = din_p[SYNC_STAGES-1];
  assign sclk_rise = cs_act & sclk_p[SYNC_STAGES-1] & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_p[SYNC_STAGES-1] & sclk_d;
endmodule

// File: rtl/sra_reg_bank.sv
module sra_reg_bank
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [2:0]        raddr,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] mode_q,
  output logic [2*BYTE_W-1:0] filt_q
);
  logic [BYTE_W-1:0] regs [NUM_REGS];

  function automatic logic [BYTE_W-1:0] init_val(input int idx);
    case (idx)
      int'(RG_FHI): return FILT_HI_INIT;
      int'(RG_FLO): return FILT_LO_INIT;
      default:      return '0;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= init_val(g);
      else if (we && waddr == 3'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata  = regs[raddr];
  assign mode_q = regs[RG_MODE];
  assign filt_q = {regs[RG_FHI], regs[RG_FLO]};
endmodule

// File: rtl/sra_ready_ctrl.sv
module sra_ready_ctrl #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned BLANK_CYC = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              hold,
  input  logic              read_done,
  output logic              rdy_n,
  output logic [DATA_W-1:0] res_q
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);

  logic [DATA_W-1:0] pend;
  logic [CW-1:0]     cnt;
  logic              busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n <= 1'b1;
      res_q <= '0;
      pend  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      if (read_done) rdy_n <= 1'b1;
      if (res_valid) begin
        pend  <= res_data;
        cnt   <= CW'(BLANK_CYC);
        busy  <= 1'b1;
        rdy_n <= 1'b1;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (!hold) begin
          res_q <= pend;
          busy  <= 1'b0;
          rdy_n <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_reg_access.sv
module serial_reg_access
  import sra_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned BLANK_CYC   = 500,
  parameter int unsigned RESYNC_ONES = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              rdy_n,
  output logic [2:0]        chan_sel,
  output logic [7:0]        mode_q,
  output logic [15:0]       filt_q
);
  localparam int unsigned BW    = $clog2(DATA_W + 1);
  localparam int unsigned OW    = $clog2(RESYNC_ONES + 1);
  localparam int unsigned PAD_W = DATA_W - BYTE_W;

  logic sclk_rise, sclk_fall, cs_act, din_s;

  sra_serial_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .din_s(din_s)
  );

  xfer_st_e          st;
  reg_sel_e          tgt;
  logic [BW-1:0]     bcnt;
  logic [OW-1:0]     ones;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_in;
  logic [DATA_W-1:0] load_val;
  logic [BW-1:0]     xfer_len;
  logic              resync, last_bit;
  logic              rf_we, rd_done;
  logic [BYTE_W-1:0] rf_rdata;
  logic [DATA_W-1:0] res_q;
  reg_sel_e          cmd_tgt;

  assign sh_in    = {sh[DATA_W-2:0], din_s};
  assign cmd_tgt  = reg_sel_e'(sh_in[6:4]);
  assign resync   = sclk_rise && din_s && (ones == OW'(RESYNC_ONES - 1));
  assign xfer_len = (tgt != RG_RES) ? BW'(BYTE_W) :
                    (mode_q[0] ? BW'(DATA_W) : BW'(DATA_W - BYTE_W));
  assign last_bit = (bcnt == xfer_len - 1'b1);

  assign rf_we   = sclk_rise && !resync && st == ST_WR && last_bit &&
                   tgt != RG_RES && tgt != RG_COMM;
  assign rd_done = sclk_rise && !resync && st == ST_RD && last_bit && tgt == RG_RES;

  sra_reg_bank u_bank (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(tgt), .wdata(sh_in[BYTE_W-1:0]),
    .raddr(cmd_tgt), .rdata(rf_rdata), .mode_q(mode_q), .filt_q(filt_q)
  );

  sra_ready_ctrl #(.DATA_W(DATA_W), .BLANK_CYC(BLANK_CYC)) u_rdy (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .hold(st == ST_RD && tgt == RG_RES), .read_done(rd_done),
    .rdy_n(rdy_n), .res_q(res_q)
  );

  always_comb begin
    case (cmd_tgt)
      RG_COMM: load_val = {rdy_n, sh_in[6:0], {PAD_W{1'b0}}};
      RG_RES:  load_val = mode_q[0] ? res_q : {res_q[DATA_W-1:BYTE_W], {BYTE_W{1'b0}}};
      default: load_val = {rf_rdata, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CMD;
      tgt      <= RG_COMM;
      bcnt     <= '0;
      ones     <= '0;
      sh       <= '0;
      chan_sel <= '0;
      dout_oe  <= 1'b0;
    end else begin
      dout_oe <= cs_act && (st == ST_RD);
      if (sclk_rise) begin
        if (!din_s)                              ones <= '0;
        else if (ones != OW'(RESYNC_ONES))       ones <= ones + 1'b1;
        if (resync) begin
          st   <= ST_CMD;
          bcnt <= '0;
        end else begin
          case (st)
            ST_CMD: begin
              sh <= sh_in;
              if (bcnt == BW'(BYTE_W - 1)) begin
                bcnt <= '0;
                if (!sh_in[7]) begin
                  tgt      <= cmd_tgt;
                  chan_sel <= sh_in[2:0];
                  if (sh_in[3]) begin
                    st <= ST_RD;
                    sh <= load_val;
                  end else if (cmd_tgt != RG_COMM) begin
                    st <= ST_WR;
                  end
                end
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
            ST_WR: begin
              sh <= sh_in;
              if (last_bit) begin
                bcnt <= '0;
                st   <= ST_CMD;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
            default: begin
              if (last_bit) begin
                bcnt <= '0;
                st   <= ST_CMD;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          endcase
        end
      end else if (sclk_fall && st == ST_RD && bcnt != '0) begin
        sh <= {sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign dout = sh[DATA_W-1];
endmodule

// File: rtl/sra_checks.sv
module sra_checks #(
  parameter int unsigned BLANK_CYC = 500
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        dout_oe,
  input logic        res_valid,
  input logic        rdy_n,
  input logic [2:0]  chan_sel,
  input logic [7:0]  mode_q,
  input logic [15:0] filt_q
);
  logic [15:0] since_strobe;
  logic        seen_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_strobe <= '0;
      seen_strobe  <= 1'b0;
    end else if (res_valid) begin
      since_strobe <= '0;
      seen_strobe  <= 1'b1;
    end else if (since_strobe != 16'hFFFF) begin
      since_strobe <= since_strobe + 1'b1;
    end
  end

  a_r9_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (filt_q == 16'h0140 && mode_q == 8'h00 && chan_sel == 3'd0 &&
                    rdy_n && !dout_oe));

  a_r5_oe_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_oe);

  a_r7_blank_after_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> rdy_n);

  a_r7_min_blank_window: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> (seen_strobe && since_strobe >= 16'(BLANK_CYC)));
endmodule

bind serial_reg_access sra_checks #(.BLANK_CYC(BLANK_CYC)) u_checks (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dout_oe(dout_oe), .res_valid(res_valid),
  .rdy_n(rdy_n), .chan_sel(chan_sel), .mode_q(mode_q), .filt_q(filt_q)
);

// File: tb/serial_reg_access_bench.sv
`timescale 1ns/1ps
module serial_reg_access_bench;
  localparam int DATA_W = 24;
  localparam int BLANK  = 500;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0, res_valid = 1'b0;
  logic [DATA_W-1:0] res_data = '0;
  logic dout, dout_oe, rdy_n;
  logic [2:0] chan_sel;
  logic [7:0] mode_q;
  logic [15:0] filt_q;

  int checks = 0, fails = 0;
  logic [7:0] aux_model [8];
  logic [DATA_W-1:0] last_res = '0;
  logic wl = 1'b0;

  always #2 clk = ~clk;

  serial_reg_access u_serial_reg_access (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .dout_oe(dout_oe), .res_valid(res_valid), .res_data(res_data), .rdy_n(rdy_n),
    .chan_sel(chan_sel), .mode_q(mode_q), .filt_q(filt_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(input logic [31:0] wv, input int n, output logic [31:0] rv);
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = wv[i];
      waitc(HALF);
      rv = {rv[30:0], dout};
      sclk = 1'b1;
      waitc(HALF);
    end
  endtask

  function automatic logic [7:0] cmd(input logic [2:0] tgt, input logic rd, input logic [2:0] ch);
    return {1'b0, tgt, rd, ch};
  endfunction

  function automatic int res_len(input logic w);
    return w ? 24 : 16;
  endfunction

  function automatic logic [31:0] res_expect(input logic [DATA_W-1:0] v, input logic w);
    return w ? 32'(v) : 32'(v[23:8]);
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v, input logic [2:0] ch);
    logic [31:0] r;
    shift(32'(cmd(a, 1'b0, ch)), 8, r);
    shift(32'(v), 8, r);
  endtask

  task automatic rd_reg(input logic [2:0] a, input int n, output logic [31:0] r);
    logic [31:0] t;
    shift(32'(cmd(a, 1'b1, 3'd0)), 8, t);
    shift(32'hFFFF_FFFF & 32'h0, n, r);
  endtask

  task automatic new_result(input logic [DATA_W-1:0] v);
    res_data = v; res_valid = 1'b1;
    waitc(1);
    res_valid = 1'b0;
    waitc(BLANK + 10);
    last_res = v;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) aux_model[i] = 8'h00;
    waitc(5); rst = 1'b0; waitc(3);

    chk("R9 filt", 32'(filt_q), 32'h0140);
    chk("R9 mode", 32'(mode_q), 32'h0);
    chk("R9 rdy_n", 32'(rdy_n), 32'h1);
    chk("R9 oe", 32'(dout_oe), 32'h0);
    cs_n = 1'b0; waitc(4);

    // R1 / R3: writes land on outputs and read back
    wr_reg(3'd2, 8'hA5, 3'd5);
    chk("R1 chan", 32'(chan_sel), 32'h5);
    chk("R3 filt hi", 32'(filt_q), 32'hA540);
    wr_reg(3'd6, 8'h3C, 3'd2);
    rd_reg(3'd6, 8, r);
    chk("R3 aux readback", r, 32'h3C);
    rd_reg(3'd3, 8, r);
    chk("R4 filt lo read", r, 32'h40);
    // R1: command write to command register, no data phase
    shift(32'(cmd(3'd0, 1'b0, 3'd6)), 8, r);
    chk("R1 comm-only chan", 32'(chan_sel), 32'h6);
    rd_reg(3'd3, 8, r);
    chk("R1 alignment after comm-only", r, 32'h40);
    rd_reg(3'd0, 8, r);
    chk("R4 comm readback", r, {24'h0, 1'b1, 3'd0, 1'b1, 3'd0});

    // R2: bit 7 set command ignored
    shift(32'hFF, 8, r);
    chk("R2 chan unchanged", 32'(chan_sel), 32'h0);
    rd_reg(3'd2, 8, r);
    chk("R2 still expects command", r, 32'hA5);

    // R10: lose alignment, then 32 ones
    shift(32'b010, 3, r);
    shift(32'hFFFF_FFFF, 32, r);
    rd_reg(3'd2, 8, r);
    chk("R10 realigned read", r, 32'hA5);

    // R5: chip select gap mid-write holds position
    shift(32'(cmd(3'd5, 1'b0, 3'd1)), 8, r);
    shift(32'hB, 4, r);
    cs_n = 1'b1; waitc(6);
    for (int k = 0; k < 3; k++) begin sclk = 1'b0; din = 1'b1; waitc(HALF); sclk = 1'b1; waitc(HALF); end
    chk("R5 oe low deselected", 32'(dout_oe), 32'h0);
    cs_n = 1'b0; waitc(4);
    shift(32'h2, 4, r);
    rd_reg(3'd5, 8, r);
    chk("R5 held position", r, 32'hB2);
    shift(32'(cmd(3'd5, 1'b1, 3'd0)), 8, r);
    shift(32'h0, 3, r);
    chk("R5 oe during read", 32'(dout_oe), 32'h1);
    shift(32'h0, 5, r);

    // R7 / R6 / R8: 16-bit result
    res_data = 24'h123456; res_valid = 1'b1; waitc(1); res_valid = 1'b0;
    waitc(5);
    chk("R7 high after strobe", 32'(rdy_n), 32'h1);
    waitc(BLANK - 20);
    chk("R7 still blank", 32'(rdy_n), 32'h1);
    waitc(30);
    chk("R7 low after window", 32'(rdy_n), 32'h0);
    last_res = 24'h123456;
    rd_reg(3'd0, 8, r);
    chk("R4 ready bit in comm", 32'(r[7]), 32'h0);
    rd_reg(3'd4, 16, r);
    chk("R6 16-bit result", r, 32'h1234);
    waitc(5);
    chk("R8 high after read", 32'(rdy_n), 32'h1);
    // R6: write to result discarded, full length consumed
    shift(32'(cmd(3'd4, 1'b0, 3'd7)), 8, r);
    shift(32'h0000_FFFF, 16, r);
    rd_reg(3'd4, 16, r);
    chk("R6 write discarded 16", r, 32'h1234);

    // switch to 24-bit words
    wr_reg(3'd1, 8'h01, 3'd0);
    wl = 1'b1;
    chk("R3 mode", 32'(mode_q), 32'h01);
    shift(32'(cmd(3'd4, 1'b0, 3'd7)), 8, r);
    shift(32'h00FF_FFFF, 24, r);
    rd_reg(3'd4, 24, r);
    chk("R6 write discarded 24", r, 32'h123456);

    // randomized results and auxiliary traffic
    for (int it = 0; it < 8; it++) begin
      logic [DATA_W-1:0] v;
      logic [7:0] b;
      logic [2:0] a;
      v = DATA_W'($urandom);
      wl = 1'($urandom);
      wr_reg(3'd1, {7'h0, wl}, 3'd0);
      new_result(v);
      chk("R7 ready random", 32'(rdy_n), 32'h0);
      rd_reg(3'd4, res_len(wl), r);
      chk("R6 random result", r, res_expect(v, wl));
      waitc(4);
      chk("R8 random ready high", 32'(rdy_n), 32'h1);
      a = 3'd5 + 3'($urandom % 3);
      b = 8'($urandom);
      aux_model[a] = b;
      wr_reg(a, b, 3'($urandom));
      rd_reg(a, 8, r);
      chk("R3 random aux", r, 32'(aux_model[a]));
    end

    cs_n = 1'b1; waitc(8);
    chk("R5 oe idle", 32'(dout_oe), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule